// File: doc/BRIEF.md
# SPI Port Register and Status Unit

This block is the register-facing half of an SPI port. A host reaches it over a simple peripheral strobe bus with a 32-bit data path: one cycle with `bus_sel` high is one access, `bus_wr` picks write or read, and read data is returned combinationally in that same cycle. The block holds the port configuration: a mode word and four per-peripheral chip-select configuration words. It also holds the transmit and receive data words and the four event flags: receive full, transmit empty, mode fault and overrun. An interrupt mask selects which flags drive one level interrupt.

The serial engine and the transfer sequencer sit outside. They see the block through three paths. A receive stream (`rx_valid` with data) has no back-pressure: each beat is taken in the cycle it is presented while the port is enabled, and a second beat that comes before software has read the previous one raises overrun. A transmit stream (`tx_valid`/`tx_ready`) presents the pending word until the serializer takes it, and a host write to the transmit register while a word is still pending replaces that word. A `xfer_busy` level tells the block that a transfer is in flight, so that a disable command waits for the transfer to end.

In master mode, the block watches the slave-select pad. If another master drives it low, the port records a mode fault and disables itself.

Top module: `spi_port_regs`

## Requirements
- R1: Registers decode from byte offsets on `bus_addr`: 0x00 control, 0x04 mode, 0x08 receive data, 0x0C transmit data, 0x10 status, 0x14 mask set, 0x18 mask clear, 0x1C mask read, 0x30/0x34/0x38/0x3C chip-select words 0..3. Address bits [1:0] are ignored. Reads of the write-only offsets (control, transmit, mask set, mask clear) and of any undefined offset return 0.
- R2: The mode word and the chip-select words reset to 0. They read back only their defined bits. For the mode word these are bit 0 master, bit 1 variable peripheral select, bit 2 decode, bit 3 clock select, bit 4 fault-detect off, bit 7 loopback, [19:16] peripheral code and [31:24] inter-select delay (read mask 0xFF0F009F). For the chip-select words, bits 2 and 3 read 0 (read mask 0xFFFFFFF3). `mode_cfg` and `cs_cfg` carry these words.
- R3: A control write with bit 0 set enables the port. A control write with bit 1 set disables it, and bit 1 wins when both bits are set. Status bit 16 shows the enabled state.
- R4: A disable command given while `xfer_busy` is high leaves the port enabled until the first cycle in which `xfer_busy` is low. The port is disabled after that cycle's clock edge.
- R5: A control write with bit 7 set returns the enable state, all flags, the mask, the mode word, the chip-select words and the data words to their reset values at the next edge.
- R6: An `rx_valid` beat while the port is enabled loads the receive word and sets status bit 0. The receive word reads with data in [15:0] and, in master mode only, `rx_pcs` in [19:16]. Reading offset 0x08 clears bit 0. Beats while the port is disabled are ignored.
- R7: A receive load while status bit 0 is set, with no receive-word read in the same cycle, sets overrun (status bit 3). Overrun stays set until the status register is read.
- R8: Transmit empty (status bit 1) is 0 at reset and while the port is disabled. The enable command sets it, a write to 0x0C clears it, and a `tx_valid`/`tx_ready` handshake sets it again. `tx_valid` is high exactly while the port is enabled and bit 1 is 0. `tx_data` is the written [15:0]. `tx_pcs` is the written [19:16] when mode bit 1 is 1, and mode [19:16] when mode bit 1 is 0.
- R9: With the port enabled, mode bit 0 = 1 and mode bit 4 = 0, a low `nss_in` at a clock edge sets mode fault (status bit 2) and disables the port. The flag stays set until the status register is read. With mode bit 4 = 1, `nss_in` has no effect.
- R10: Ones written to 0x14 set mask bits, and ones written to 0x18 clear them. 0x1C reads the mask in bits [3:0], which use the same positions as the status flags. `irq` is high when any of status bits [3:0] is high together with its mask bit.
- R11: `pad_oe_n` (active low; bit 0 data-out-in-slave, bit 1 data-out-in-master, bit 2 serial clock, bit 3 chip selects) is all ones while the port is disabled. While enabled in master mode it is 4'b0001, and while enabled in slave mode it is 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Received word beat from the serializer |
| rx_data | input | 16 | Received word, right-justified |
| rx_pcs | input | 4 | Chip-select pad value at end of transfer |
| tx_valid | output | 1 | A transmit word is pending |
| tx_ready | input | 1 | Serializer takes the pending word |
| tx_data | output | 16 | Pending transmit word |
| tx_pcs | output | 4 | Peripheral code for the pending word |
| xfer_busy | input | 1 | Transfer in flight |
| nss_in | input | 1 | Slave-select pad level |
| mode_cfg | output | 32 | Mode word |
| cs_cfg | output | 128 | Chip-select words, word i at [32*i+31:32*i] |
| pad_oe_n | output | 4 | Pad output enables, active low |

## Verification
The hardest states to reach are the ones where two events land in the same cycle, and the ones where a command must wait on the outside world. Examples are a disable command that arrives while a transfer is in flight, and a mode fault while the port is enabled as master. The stimulus holds `xfer_busy` high across the disable write and reads status while the disable is still pending. It then drops `xfer_busy` and reads status again. For the fault, it switches the port to master while it is enabled and pulls `nss_in` low. The same pull is repeated with fault detection turned off, to show that it has no effect then.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam int CS_COUNT = 4;
  localparam int FLAG_W   = 4;

  // byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_RXD  = 'h08;
  localparam int OFF_TXD  = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_MSET = 'h14;
  localparam int OFF_MCLR = 'h18;
  localparam int OFF_MASK = 'h1C;
  localparam int OFF_CS0  = 'h30;

  // control bits
  localparam int CTL_EN   = 0;
  localparam int CTL_DIS  = 1;
  localparam int CTL_RST  = 7;

  // status bits (flag bits also index the mask)
  localparam int ST_RXF   = 0;
  localparam int ST_TXE   = 1;
  localparam int ST_FAULT = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_ON    = 16;

  // mode bits
  localparam int MD_MASTER = 0;
  localparam int MD_VARSEL = 1;
  localparam int MD_NOFLT  = 4;
  localparam int PCS_LSB   = 16;
  localparam int PCS_W     = 4;

  localparam logic [31:0] MODE_KEEP = 32'hFF0F_009F;
  localparam logic [31:0] CS_KEEP   = 32'hFFFF_FFF3;

  // pad output-enable positions
  localparam int OE_SLV_DO = 0;
  localparam int OE_MST_DO = 1;
  localparam int OE_SCK    = 2;
  localparam int OE_SEL    = 3;

  typedef struct packed {
    logic                ctrl;
    logic                mode;
    logic                rxd;
    logic                txd;
    logic                stat;
    logic                mset;
    logic                mclr;
    logic                mask;
    logic [CS_COUNT-1:0] cs;
  } reg_hit_t;

endpackage

// File: rtl/spi_reg_decode.sv
module spi_reg_decode
  import spi_regs_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W-1:0] word_addr,
  output reg_hit_t          hit
);

  function automatic logic at(input logic [WORD_W-1:0] w, input int byte_off);
    return w == WORD_W'(byte_off >> 2);
  endfunction

  logic [CS_COUNT-1:0] cs_hit;

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign cs_hit[i] = at(word_addr, OFF_CS0 + 4 * i);
  end

  assign hit.ctrl = at(word_addr, OFF_CTRL);
  assign hit.mode = at(word_addr, OFF_MODE);
  assign hit.rxd  = at(word_addr, OFF_RXD);
  assign hit.txd  = at(word_addr, OFF_TXD);
  assign hit.stat = at(word_addr, OFF_STAT);
  assign hit.mset = at(word_addr, OFF_MSET);
  assign hit.mclr = at(word_addr, OFF_MCLR);
  assign hit.mask = at(word_addr, OFF_MASK);
  assign hit.cs   = cs_hit;

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic en_cmd,
  input  logic dis_cmd,
  input  logic xfer_busy,
  input  logic master,
  input  logic fault_off,
  input  logic nss_in,
  input  logic rx_load,
  input  logic rxd_read,
  input  logic stat_read,
  input  logic txd_write,
  input  logic tx_take,
  output logic enabled,
  output logic rxf,
  output logic txe,
  output logic fault,
  output logic ovr
);

  logic pend_q, en_nxt, pend_nxt, en_set, fault_hit;

  assign fault_hit = enabled && master && !fault_off && !nss_in;

  always_comb begin
    en_nxt   = enabled;
    pend_nxt = pend_q;
    en_set   = 1'b0;
    if (fault_hit) begin
      en_nxt   = 1'b0;
      pend_nxt = 1'b0;
    end else if (dis_cmd) begin
      if (xfer_busy) pend_nxt = 1'b1;
      else begin
        en_nxt   = 1'b0;
        pend_nxt = 1'b0;
      end
    end else if (en_cmd) begin
      en_nxt   = 1'b1;
      pend_nxt = 1'b0;
      en_set   = 1'b1;
    end else if (pend_q && !xfer_busy) begin
      en_nxt   = 1'b0;
      pend_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      pend_q  <= 1'b0;
      rxf     <= 1'b0;
      txe     <= 1'b0;
      fault   <= 1'b0;
      ovr     <= 1'b0;
    end else if (srst) begin
      enabled <= 1'b0;
      pend_q  <= 1'b0;
      rxf     <= 1'b0;
      txe     <= 1'b0;
      fault   <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      enabled <= en_nxt;
      pend_q  <= pend_nxt;

      if (!en_nxt)        txe <= 1'b0;
      else if (en_set)    txe <= 1'b1;
      else if (txd_write) txe <= 1'b0;
      else if (tx_take)   txe <= 1'b1;

      if (rx_load)       rxf <= 1'b1;
      else if (rxd_read) rxf <= 1'b0;

      if (rx_load && rxf && !rxd_read) ovr <= 1'b1;
      else if (stat_read)              ovr <= 1'b0;

      if (fault_hit)      fault <= 1'b1;
      else if (stat_read) fault <= 1'b0;
    end
  end

  p_dis_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && dis_cmd && !xfer_busy && !srst) |=> !enabled);

  p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cmd && xfer_busy && enabled && !fault_hit && !srst) |=> enabled);

  p_swreset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!enabled && !rxf && !txe && !fault && !ovr));

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rxf && !rxd_read && !srst) |=> ovr);

  p_txe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !txe);

  p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !srst) |=> (fault && !enabled));

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (srst)   mask <= '0;
    else if (set_we) mask <= mask | bits;
    else if (clr_we) mask <= mask & ~bits;
  end

  assign irq = |(flags & mask);

  p_mask_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !srst) |=> ((mask & $past(bits)) == $past(bits)));

  p_mask_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((mask & $past(bits)) == '0));

endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq,
  input  logic                   rx_valid,
  input  logic [DATA_W-1:0]      rx_data,
  input  logic [PCS_W-1:0]       rx_pcs,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [DATA_W-1:0]      tx_data,
  output logic [PCS_W-1:0]       tx_pcs,
  input  logic                   xfer_busy,
  input  logic                   nss_in,
  output logic [31:0]            mode_cfg,
  output logic [32*CS_COUNT-1:0] cs_cfg,
  output logic [3:0]             pad_oe_n
);

  localparam int WORD_W = ADDR_W - 2;

  reg_hit_t hit;
  logic wr, rd;
  logic [31:0] mode_q;
  logic [31:0] cs_q [CS_COUNT];
  logic [DATA_W-1:0] rxd_q, txd_q;
  logic [PCS_W-1:0]  rxp_q, txp_q;
  logic enabled, rxf, txe, fault, ovr;
  logic [FLAG_W-1:0] flags, mask;
  logic srst, rx_load, tx_take;
  logic unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];

  assign wr = bus_sel && bus_wr;
  assign rd = bus_sel && !bus_wr;
  assign srst = wr && hit.ctrl && bus_wdata[CTL_RST];
  assign rx_load = rx_valid && enabled;
  assign tx_valid = enabled && !txe;
  assign tx_take = tx_valid && tx_ready;

  spi_reg_decode #(.WORD_W(WORD_W)) u_dec (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .hit       (hit)
  );

  spi_flag_unit u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst      (srst),
    .en_cmd    (wr && hit.ctrl && bus_wdata[CTL_EN]),
    .dis_cmd   (wr && hit.ctrl && bus_wdata[CTL_DIS]),
    .xfer_busy (xfer_busy),
    .master    (mode_q[MD_MASTER]),
    .fault_off (mode_q[MD_NOFLT]),
    .nss_in    (nss_in),
    .rx_load   (rx_load),
    .rxd_read  (rd && hit.rxd),
    .stat_read (rd && hit.stat),
    .txd_write (wr && hit.txd),
    .tx_take   (tx_take),
    .enabled   (enabled),
    .rxf       (rxf),
    .txe       (txe),
    .fault     (fault),
    .ovr       (ovr)
  );

  always_comb begin
    flags           = '0;
    flags[ST_RXF]   = rxf;
    flags[ST_TXE]   = txe;
    flags[ST_FAULT] = fault;
    flags[ST_OVR]   = ovr;
  end

  spi_irq_mask #(.W(FLAG_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (srst),
    .set_we (wr && hit.mset),
    .clr_we (wr && hit.mclr),
    .bits   (bus_wdata[FLAG_W-1:0]),
    .flags  (flags),
    .mask   (mask),
    .irq    (irq)
  );

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mode_q <= '0;
    else if (srst)               mode_q <= '0;
    else if (wr && hit.mode)     mode_q <= bus_wdata & MODE_KEEP;
  end

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cs_q[i] <= '0;
      else if (srst)              cs_q[i] <= '0;
      else if (wr && hit.cs[i])   cs_q[i] <= bus_wdata & CS_KEEP;
    end
    assign cs_cfg[32*i +: 32] = cs_q[i];
  end

  assign mode_cfg = mode_q;

  // data words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= '0;
      rxp_q <= '0;
      txd_q <= '0;
      txp_q <= '0;
    end else if (srst) begin
      rxd_q <= '0;
      rxp_q <= '0;
      txd_q <= '0;
      txp_q <= '0;
    end else begin
      if (rx_load) begin
        rxd_q <= rx_data;
        rxp_q <= mode_q[MD_MASTER] ? rx_pcs : '0;
      end
      if (wr && hit.txd) begin
        txd_q <= bus_wdata[DATA_W-1:0];
        txp_q <= bus_wdata[PCS_LSB +: PCS_W];
      end
    end
  end

  assign tx_data = txd_q;
  assign tx_pcs  = mode_q[MD_VARSEL] ? txp_q : mode_q[PCS_LSB +: PCS_W];

  // read path
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit.mode) bus_rdata = mode_q;
      if (hit.rxd) begin
        bus_rdata[DATA_W-1:0]        = rxd_q;
        bus_rdata[PCS_LSB +: PCS_W]  = rxp_q;
      end
      if (hit.stat) begin
        bus_rdata[FLAG_W-1:0] = flags;
        bus_rdata[ST_ON]      = enabled;
      end
      if (hit.mask) bus_rdata[FLAG_W-1:0] = mask;
      for (int i = 0; i < CS_COUNT; i++)
        if (hit.cs[i]) bus_rdata = cs_q[i];
    end
  end

  // pads
  always_comb begin
    pad_oe_n = '1;
    if (enabled) begin
      if (mode_q[MD_MASTER]) begin
        pad_oe_n[OE_MST_DO] = 1'b0;
        pad_oe_n[OE_SCK]    = 1'b0;
        pad_oe_n[OE_SEL]    = 1'b0;
      end else begin
        pad_oe_n[OE_SLV_DO] = 1'b0;
      end
    end
  end

  p_rx_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !srst) |=> (rxd_q == $past(rx_data)));

  p_rx_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !srst) |=> $stable(rxd_q));

  p_oe_master_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && mode_q[MD_MASTER]) |-> pad_oe_n[OE_SLV_DO]);

  p_one_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> $onehot0(hit));

endmodule

// File: tb/spi_port_regs_bench.sv
module spi_port_regs_bench;

  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [13:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic         rx_valid = 1'b0;
  logic [15:0]  rx_data = '0;
  logic [3:0]   rx_pcs = '0;
  logic         tx_valid, tx_ready = 1'b0;
  logic [15:0]  tx_data;
  logic [3:0]   tx_pcs;
  logic         xfer_busy = 1'b0, nss_in = 1'b1;
  logic [31:0]  mode_cfg;
  logic [127:0] cs_cfg;
  logic [3:0]   pad_oe_n;

  int n_chk = 0, n_bad = 0;
  logic [31:0] r;

  always #(CLK_NS / 2) clk = ~clk;

  spi_port_regs u_spi_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_pcs(rx_pcs),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_pcs(tx_pcs), .xfer_busy(xfer_busy), .nss_in(nss_in),
    .mode_cfg(mode_cfg), .cs_cfg(cs_cfg), .pad_oe_n(pad_oe_n)
  );

  typedef struct packed {
    logic        wr;
    logic [13:0] addr;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 14'h04, 32'h0, 32'h0, 4'd2},               // R2 reset value
    '{1'b1, 14'h04, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 14'h04, 32'h0, 32'hFF0F_009F, 4'd2},       // R2 mode mask
    '{1'b0, 14'h07, 32'h0, 32'hFF0F_009F, 4'd1},       // R1 low bits ignored
    '{1'b1, 14'h34, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 14'h34, 32'h0, 32'hFFFF_FFF3, 4'd2},       // R2 cs mask
    '{1'b0, 14'h30, 32'h0, 32'h0, 4'd2},               // R2 other cs untouched
    '{1'b0, 14'h20, 32'h0, 32'h0, 4'd1},               // R1 undefined offset
    '{1'b0, 14'h0C, 32'h0, 32'h0, 4'd1},               // R1 write-only
    '{1'b1, 14'h14, 32'h0000_000F, 32'h0, 4'd0},
    '{1'b0, 14'h1C, 32'h0, 32'h0000_000F, 4'd10},      // R10 mask set
    '{1'b1, 14'h18, 32'h0000_0005, 32'h0, 4'd0},
    '{1'b0, 14'h1C, 32'h0, 32'h0000_000A, 4'd10},      // R10 mask clear
    '{1'b1, 14'h04, 32'h0, 32'h0, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [13:0] a, input logic [31:0] d,
                     output logic [31:0] rv);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1 rv = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus(1'b1, a, d, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [13:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus(1'b0, a, 32'h0, v);
    check(req, v, exp);
  endtask

  task automatic rx_push(input logic [15:0] d, input logic [3:0] p);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_pcs = p;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic tx_pull();
    @(negedge clk);
    tx_ready = 1'b1;
    @(posedge clk);
    #1 tx_ready = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R5 R8 R10 R11 reset state
    check("R8 tx_valid at reset", {31'b0, tx_valid}, 32'h0);
    check("R10 irq at reset", {31'b0, irq}, 32'h0);
    check("R11 pads at reset", {28'b0, pad_oe_n}, 32'hF);
    rd_chk("R3 status at reset", 14'h10, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].addr, VECS[i].d, r);
      if (!VECS[i].wr) begin
        n_chk++;
        if (r !== VECS[i].exp) begin
          n_bad++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].req, i, r, VECS[i].exp);
        end
      end
    end
    check("R2 cs_cfg word 1", cs_cfg[63:32], 32'hFFFF_FFF3);

    // R3 enable, R11 slave pads, R10 irq from tx empty
    wr(14'h00, 32'h1);
    check("R11 slave pads", {28'b0, pad_oe_n}, 32'hE);
    check("R10 irq on tx empty", {31'b0, irq}, 32'h1);
    rd_chk("R3 enabled status", 14'h10, 32'h0001_0002);

    // R8 transmit path
    wr(14'h0C, 32'h0003_A5A5);
    check("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
    check("R8 tx_data", {16'b0, tx_data}, 32'hA5A5);
    check("R8 tx_pcs fixed", {28'b0, tx_pcs}, 32'h0);
    check("R10 irq masked off", {31'b0, irq}, 32'h0);
    rd_chk("R8 status after write", 14'h10, 32'h0001_0000);
    tx_pull();
    check("R8 tx_valid after take", {31'b0, tx_valid}, 32'h0);
    rd_chk("R8 status after take", 14'h10, 32'h0001_0002);

    // R6 R7 receive and overrun
    rx_push(16'h1234, 4'h5);
    rd_chk("R6 rx word slave", 14'h08, 32'h0000_1234);
    rd_chk("R6 rx full cleared", 14'h10, 32'h0001_0002);
    rx_push(16'h1111, 4'h0);
    rx_push(16'h2222, 4'h0);
    check("R10 irq with overrun", {31'b0, irq}, 32'h1);
    rd_chk("R7 overrun set", 14'h10, 32'h0001_000B);
    rd_chk("R7 overrun cleared by read", 14'h10, 32'h0001_0003);
    rd_chk("R6 latest rx word", 14'h08, 32'h0000_2222);

    // R9 mode fault
    wr(14'h04, 32'h0005_0001);
    check("R11 master pads", {28'b0, pad_oe_n}, 32'h1);
    @(negedge clk) nss_in = 1'b0;
    @(posedge clk);
    #1 check("R11 pads after fault", {28'b0, pad_oe_n}, 32'hF);
    rd_chk("R9 fault status", 14'h10, 32'h0000_0004);
    rd_chk("R9 fault cleared", 14'h10, 32'h0000_0000);
    @(negedge clk) nss_in = 1'b1;
    wr(14'h04, 32'h0005_0011);
    wr(14'h00, 32'h1);
    @(negedge clk) nss_in = 1'b0;
    repeat (2) @(posedge clk);
    #1 nss_in = 1'b1;
    rd_chk("R9 detection off", 14'h10, 32'h0001_0002);

    // R6 master pcs
    rx_push(16'hBEEF, 4'h6);
    rd_chk("R6 rx word master", 14'h08, 32'h0006_BEEF);

    // R8 variable select
    wr(14'h04, 32'h0005_0013);
    wr(14'h0C, 32'h000C_0042);
    check("R8 tx_pcs variable", {28'b0, tx_pcs}, 32'hC);
    check("R8 tx_data 2", {16'b0, tx_data}, 32'h0042);
    wr(14'h04, 32'h0005_0011);
    check("R8 tx_pcs fixed code", {28'b0, tx_pcs}, 32'h5);
    tx_pull();

    // R4 deferred disable
    @(negedge clk) xfer_busy = 1'b1;
    wr(14'h00, 32'h3);
    rd_chk("R4 still enabled while busy", 14'h10, 32'h0001_0002);
    @(negedge clk) xfer_busy = 1'b0;
    @(posedge clk);
    rd_chk("R4 disabled after busy", 14'h10, 32'h0);

    // R3 both bits, not busy
    wr(14'h00, 32'h1);
    wr(14'h00, 32'h3);
    rd_chk("R3 disable wins", 14'h10, 32'h0);

    // R5 software reset
    wr(14'h00, 32'h1);
    wr(14'h14, 32'hF);
    rx_push(16'h5555, 4'h0);
    check("R10 irq before reset", {31'b0, irq}, 32'h1);
    wr(14'h00, 32'h80);
    check("R5 irq cleared", {31'b0, irq}, 32'h0);
    check("R5 pads", {28'b0, pad_oe_n}, 32'hF);
    rd_chk("R5 status", 14'h10, 32'h0);
    rd_chk("R5 mask", 14'h1C, 32'h0);
    rd_chk("R5 mode", 14'h04, 32'h0);
    rd_chk("R5 cs word", 14'h34, 32'h0);
    rd_chk("R5 rx word", 14'h08, 32'h0);

    // R6 ignored while disabled
    rx_push(16'h7777, 4'h0);
    rd_chk("R6 status unchanged", 14'h10, 32'h0);
    rd_chk("R6 rx word unchanged", 14'h08, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule